// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block is the configuration-access front end of a host bridge. Host software first writes a 32-bit configuration address into an index register. It then reads or writes a data window. Each data-window access becomes exactly one configuration transaction on a request/acknowledge interface. The block rewrites the stored index into a normalised bus/devfn/register address, merging in the low offset bits of the data access. Write data is moved onto the correct byte lanes, with matching byte enables. Read data is brought back to the host right-aligned.

The index value is read in one of three formats, chosen by its bit 31 and bit 0:
- a pass-through format;
- a Type-1 format;
- a Type-0 format, in which the device is selected by a one-hot bit in the upper index bits. A trailing-zero priority encoder turns that bit into a slot number.

The block also rotates the four interrupt pins of each device slot onto four shared interrupt lines. The rotation depends on the slot number.

Top module: `cfgx_top`

## Requirements
- R1: After a synchronous active-low reset, the index register reads 0x00000000, `cfg_req` is low and `host_ack` is low.
- R2: An access to the index window (`host_win`=0) completes with `host_ack` high in the cycle after the request is sampled. Writes update only the byte lanes selected by size and `host_off[1:0]`, little-endian. Reads return the stored value shifted down by `host_off[1:0]` bytes and masked to the access size. A new index value is used by the next data-window access.
- R3: When index bit 31 is 1, `cfg_addr` equals the index with bits 1:0 replaced by `host_off[1:0]`.
- R4: When index bit 31 is 0 and bit 0 is 1, `cfg_addr` equals the index with bits 2:0 replaced by `host_off[2:0]`.
- R5: When index bits 31 and 0 are both 0, `cfg_addr` is built as follows:
  - bits 31:16 are zero;
  - bits 15:11 hold the position (11..31) of the lowest set bit among index bits 31:11;
  - bits 10:8 hold index bits 10:8;
  - bits 7:3 hold index bits 7:3;
  - bits 2:0 hold `host_off[2:0]`.
- R6: In the R5 format, if index bits 31:11 are all zero, `cfg_addr` bits 15:11 are 5'b11111.
- R7: `host_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. `cfg_be` is that many low ones shifted left by `host_off[1:0]`, truncated to 4 bits. `cfg_wdata` is `host_wdata` shifted left by 8*`host_off[1:0]`, with disabled bytes zero. `cfg_we` follows `host_we`.
- R8: `cfg_req` rises in the cycle after a data-window request is sampled. `cfg_req`, `cfg_addr`, `cfg_be`, `cfg_we` and `cfg_wdata` then stay stable until `cfg_ack` is sampled high. In the following cycle `cfg_req` is low and `host_ack` is high for one cycle.
- R9: For a data-window read, `host_rdata` is `cfg_rdata` as sampled with `cfg_ack`, shifted down by 8*`host_off[1:0]` and masked to the access size.
- R10: Device slot i (slot number FIRST_SLOT+i) has pins 0..3 on `dev_int[4*i+3:4*i]`. Each `host_int[n]` is the OR of every pin p whose (p + slot number) mod 4 equals n.
- R11: A `host_req` that arrives while a configuration transaction is outstanding, or while `host_ack` is high, is ignored. It changes neither the index nor the pending transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host access strobe |
| host_win | input | 1 | Window select: 0 index, 1 data |
| host_we | input | 1 | 1 = write, 0 = read |
| host_off | input | 3 | Byte offset within the window (low bits) |
| host_size | input | 2 | Access size code |
| host_wdata | input | 32 | Right-aligned write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Right-aligned read data |
| cfg_req | output | 1 | Configuration request, held until acknowledged |
| cfg_we | output | 1 | Configuration write flag |
| cfg_addr | output | 32 | Normalised configuration address |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_ack | input | 1 | Configuration acknowledge |
| cfg_rdata | input | 32 | Configuration read data, valid with `cfg_ack` |
| dev_int | input | NUM_SLOTS*4 | Per-slot interrupt pins |
| host_int | output | 4 | Rotated shared interrupt lines |

## Verification
The bench builds the block with NUM_SLOTS=8 and FIRST_SLOT=11. Slots 11 to 18 cover every residue mod 4 twice, so each of the four rotation offsets sends pins to all four shared lines. The Type-0 slot values that can appear (11..31, and 31 again for the no-IDSEL case) all fit the 5-bit devfn slot field. Random index values are drawn in each of the three formats and paired with random offsets, sizes and acknowledge delays. This reaches every lane and enable pattern, including enables truncated at the top lane.

// File: rtl/cfgx_pkg.sv
// Package: shared constants, access-size type and helpers for the
// configuration address translator.
// Assumes a 32-bit configuration address and a 4-byte data path.
package cfgx_pkg;

    localparam int CFG_AW   = 32;
    localparam int DATA_W   = 32;
    localparam int BE_W     = DATA_W / 8;
    localparam int IDSEL_LO = 11;   // lowest index bit used as a one-hot device select
    localparam int LINES    = 4;    // shared interrupt lines

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WRD3 = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        FMT_PASS  = 2'd0,
        FMT_TYPE1 = 2'd1,
        FMT_TYPE0 = 2'd2
    } idx_fmt_e;

    // Byte-count mask of an access, before lane shifting.
    function automatic logic [BE_W-1:0] size_be(input logic [1:0] sz);
        case (acc_size_e'(sz))
            SZ_BYTE: size_be = 4'b0001;
            SZ_HALF: size_be = 4'b0011;
            default: size_be = 4'b1111;
        endcase
    endfunction

    // Bring lane data down to bit 0 and keep only the bytes of the access size.
    function automatic logic [DATA_W-1:0] align_rd(input logic [DATA_W-1:0] raw,
                                                   input logic [1:0] off,
                                                   input logic [1:0] sz);
        logic [DATA_W-1:0] shifted;
        logic [DATA_W-1:0] keep;
        shifted = raw >> {off, 3'b000};
        case (acc_size_e'(sz))
            SZ_BYTE: keep = 32'h0000_00FF;
            SZ_HALF: keep = 32'h0000_FFFF;
            default: keep = 32'hFFFF_FFFF;
        endcase
        align_rd = shifted & keep;
    endfunction

endpackage

// File: rtl/cfgx_decode.sv
// Module: cfgx_decode
// Turns the stored index value and the data-window offset into a
// normalised configuration address. The format is picked by index bit 31
// and bit 0. Type-0 slot numbers come from a trailing-zero scan over the
// one-hot select field. Purely combinational; the caller registers the result.
module cfgx_decode
    import cfgx_pkg::*;
(
    input  logic [CFG_AW-1:0] idx,
    input  logic [2:0]        off,
    output logic [CFG_AW-1:0] xaddr
);

    localparam int SLOT_W = 5;

    idx_fmt_e          fmt;
    logic [SLOT_W-1:0] slot;
    logic [7:0]        devfn;

    // Classify the index format from its marker bits.
    always_comb begin
        if (idx[CFG_AW-1])  fmt = FMT_PASS;
        else if (idx[0])    fmt = FMT_TYPE1;
        else                fmt = FMT_TYPE0;
    end

    // Trailing-zero priority scan: the lowest set select bit wins; none gives all ones.
    always_comb begin
        slot = '1;
        for (int k = CFG_AW - 1; k >= IDSEL_LO; k--) begin
            if (idx[k]) slot = SLOT_W'(k);
        end
    end

    // Device/function byte for the Type-0 form.
    assign devfn = {slot, idx[10:8]};

    // Assemble the translated address for the chosen format.
    always_comb begin
        case (fmt)
            FMT_PASS:  xaddr = {idx[CFG_AW-1:2], off[1:0]};
            FMT_TYPE1: xaddr = {idx[CFG_AW-1:3], off};
            default:   xaddr = {16'h0000, devfn, idx[7:3], off};
        endcase
    end

endmodule

// File: rtl/cfgx_lane.sv
// Module: cfgx_lane
// Derives byte enables, a per-bit lane mask and lane-shifted write data
// from the access size and the low two offset bits (little-endian lanes).
// Enables that would fall past lane 3 are dropped.
module cfgx_lane
    import cfgx_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [1:0]        off,
    input  logic [DATA_W-1:0] wdata,
    output logic [BE_W-1:0]   be,
    output logic [DATA_W-1:0] bmask,
    output logic [DATA_W-1:0] wlane
);

    logic [2*BE_W-1:0] be_wide;

    // Shift the size mask into place; truncate the overflow lanes.
    always_comb begin
        be_wide = {{BE_W{1'b0}}, size_be(size)} << off;
        be      = be_wide[BE_W-1:0];
    end

    // Expand each byte enable into eight mask bits.
    for (genvar b = 0; b < BE_W; b++) begin : g_mask
        assign bmask[8*b +: 8] = {8{be[b]}};
    end

    // Move right-aligned host data onto its byte lanes.
    assign wlane = wdata << {off, 3'b000};

endmodule

// File: rtl/cfgx_irq_map.sv
// Module: cfgx_irq_map
// Rotates the four interrupt pins of each device slot onto four shared lines:
// pin p of slot number s drives line (p + s) mod 4. The wiring is fixed at
// elaboration from FIRST_SLOT; the only logic is an OR per line.
module cfgx_irq_map
    import cfgx_pkg::*;
#(
    parameter int NUM_SLOTS  = 8,
    parameter int FIRST_SLOT = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SLOTS*4-1:0]  dev_int,
    output logic [LINES-1:0]        host_int
);

    localparam int NSRC = NUM_SLOTS * 4;

    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic [NSRC-1:0] hit;
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            for (genvar p = 0; p < 4; p++) begin : g_pin
                if (((p + FIRST_SLOT + s) % LINES) == l) begin : g_on
                    assign hit[s*4+p] = dev_int[s*4+p];
                end else begin : g_off
                    assign hit[s*4+p] = 1'b0;
                end
            end
        end
        // Merge every pin routed to this line.
        assign host_int[l] = |hit;
    end

    // R10: no pin asserted means no line asserted
    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_int == '0) |-> (host_int == '0));

    // R10: each active line needs at least one active pin
    p_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(host_int) <= $countones(dev_int));

endmodule

// File: rtl/cfgx_top.sv
// Module: cfgx_top
// Configuration-access front end of a host bridge. Holds the index register,
// translates it on each data-window access, and issues one registered
// configuration request that is held until acknowledged. Also rotates the
// device interrupt pins onto the shared lines.
// Assumes the host waits for host_ack before its next request.
module cfgx_top
    import cfgx_pkg::*;
#(
    parameter int NUM_SLOTS  = 8,
    parameter int FIRST_SLOT = 11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_req,
    input  logic                   host_win,
    input  logic                   host_we,
    input  logic [2:0]             host_off,
    input  logic [1:0]             host_size,
    input  logic [DATA_W-1:0]      host_wdata,
    output logic                   host_ack,
    output logic [DATA_W-1:0]      host_rdata,
    output logic                   cfg_req,
    output logic                   cfg_we,
    output logic [CFG_AW-1:0]      cfg_addr,
    output logic [BE_W-1:0]        cfg_be,
    output logic [DATA_W-1:0]      cfg_wdata,
    input  logic                   cfg_ack,
    input  logic [DATA_W-1:0]      cfg_rdata,
    input  logic [NUM_SLOTS*4-1:0] dev_int,
    output logic [LINES-1:0]       host_int
);

    typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} state_e;

    state_e             st_q;
    logic [CFG_AW-1:0]  idx_q;
    logic               ack_q;
    logic [DATA_W-1:0]  rdata_q;
    logic               req_q;
    logic               we_q;
    logic [CFG_AW-1:0]  addr_q;
    logic [BE_W-1:0]    be_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [1:0]         off_q;
    logic [1:0]         size_q;

    logic [CFG_AW-1:0]  xaddr;
    logic [BE_W-1:0]    be_w;
    logic [DATA_W-1:0]  bmask_w;
    logic [DATA_W-1:0]  wlane_w;
    logic               accept;

    cfgx_decode u_decode (
        .idx   (idx_q),
        .off   (host_off),
        .xaddr (xaddr)
    );

    cfgx_lane u_lane (
        .size  (host_size),
        .off   (host_off[1:0]),
        .wdata (host_wdata),
        .be    (be_w),
        .bmask (bmask_w),
        .wlane (wlane_w)
    );

    cfgx_irq_map #(
        .NUM_SLOTS  (NUM_SLOTS),
        .FIRST_SLOT (FIRST_SLOT)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .dev_int  (dev_int),
        .host_int (host_int)
    );

    // Take a host request only when idle and not in the acknowledge cycle.
    assign accept = host_req && !ack_q && (st_q == ST_IDLE);

    // Index register, transaction registers and the host handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            idx_q   <= '0;
            ack_q   <= 1'b0;
            rdata_q <= '0;
            req_q   <= 1'b0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            off_q   <= '0;
            size_q  <= '0;
        end else begin
            ack_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (accept && !host_win) begin
                        if (host_we) idx_q <= (idx_q & ~bmask_w) | (wlane_w & bmask_w);
                        else         rdata_q <= align_rd(idx_q, host_off[1:0], host_size);
                        ack_q <= 1'b1;
                    end else if (accept) begin
                        req_q   <= 1'b1;
                        we_q    <= host_we;
                        addr_q  <= xaddr;
                        be_q    <= be_w;
                        wdata_q <= wlane_w & bmask_w;
                        off_q   <= host_off[1:0];
                        size_q  <= host_size;
                        st_q    <= ST_WAIT;
                    end
                end
                default: begin
                    if (cfg_ack) begin
                        req_q <= 1'b0;
                        ack_q <= 1'b1;
                        if (!we_q) rdata_q <= align_rd(cfg_rdata, off_q, size_q);
                        st_q  <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign host_ack   = ack_q;
    assign host_rdata = rdata_q;
    assign cfg_req    = req_q;
    assign cfg_we     = we_q;
    assign cfg_addr   = addr_q;
    assign cfg_be     = be_q;
    assign cfg_wdata  = wdata_q;

    // R1: reset clears the handshake outputs
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!req_q && !ack_q && idx_q == '0));

    // R8: request and its payload hold until acknowledged
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !cfg_ack) |=> (req_q && $stable(addr_q) && $stable(be_q)
                                 && $stable(wdata_q) && $stable(we_q)));

    // R8: acknowledge ends the request and pulses host_ack
    p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && cfg_ack) |=> (!req_q && ack_q));

    // R2: host_ack is a single-cycle pulse
    p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |=> !ack_q);

    // R11: the index cannot change while a transaction is outstanding
    p_busy_idx_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT) |=> $stable(idx_q));

    // R7: every issued request enables at least one byte
    p_be_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> (be_q != '0));

    // R3: pass-through format keeps the upper index bits
    p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_q) && idx_q[CFG_AW-1]) |-> (addr_q[CFG_AW-1:2] == idx_q[CFG_AW-1:2]));

    // R6: Type-0 without a select bit forces the slot field to all ones
    p_noidsel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_q) && idx_q[CFG_AW-1:IDSEL_LO] == '0 && !idx_q[0])
            |-> (addr_q[15:11] == 5'h1F && addr_q[CFG_AW-1:16] == '0));

endmodule

// File: tb/tb_cfgx_top.sv
// Bench for cfgx_top: directed corner cases plus seeded random accesses,
// compared against expected values computed from the requirements.
module tb_cfgx_top;

    localparam int NS = 8;
    localparam int FS = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             host_req = 1'b0;
    logic             host_win = 1'b0;
    logic             host_we = 1'b0;
    logic [2:0]       host_off = '0;
    logic [1:0]       host_size = '0;
    logic [31:0]      host_wdata = '0;
    logic             host_ack;
    logic [31:0]      host_rdata;
    logic             cfg_req;
    logic             cfg_we;
    logic [31:0]      cfg_addr;
    logic [3:0]       cfg_be;
    logic [31:0]      cfg_wdata;
    logic             cfg_ack = 1'b0;
    logic [31:0]      cfg_rdata = '0;
    logic [NS*4-1:0]  dev_int = '0;
    logic [3:0]       host_int;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    cfgx_top #(.NUM_SLOTS(NS), .FIRST_SLOT(FS)) dut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_win(host_win), .host_we(host_we),
        .host_off(host_off), .host_size(host_size), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_rdata(host_rdata),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata),
        .dev_int(dev_int), .host_int(host_int)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---- expected-value models ----
    function automatic logic [31:0] exp_xlate(input logic [31:0] idx, input logic [2:0] off);
        logic [4:0] s;
        if (idx[31]) return {idx[31:2], off[1:0]};
        if (idx[0])  return {idx[31:3], off};
        s = 5'h1F;
        for (int k = 11; k < 32; k++) begin
            if (idx[k]) begin s = 5'(k); break; end
        end
        return {16'h0, s, idx[10:8], idx[7:3], off};
    endfunction

    function automatic string fmt_tag(input logic [31:0] idx);
        if (idx[31]) return "R3";
        if (idx[0])  return "R4";
        if (idx[31:11] == '0) return "R6";
        return "R5";
    endfunction

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] off);
        logic [7:0] m;
        m = 8'((1 << nbytes(sz)) - 1) << off;
        return m[3:0];
    endfunction

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int b = 0; b < 4; b++) m[8*b +: 8] = be[b] ? 8'hFF : 8'h00;
        return m;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [31:0] raw, input logic [1:0] off,
                                           input logic [1:0] sz);
        logic [31:0] v;
        v = raw >> (8 * off);
        if (nbytes(sz) == 1) v = v & 32'hFF;
        else if (nbytes(sz) == 2) v = v & 32'hFFFF;
        return v;
    endfunction

    function automatic logic [3:0] exp_irq(input logic [NS*4-1:0] d);
        logic [3:0] r = '0;
        for (int s = 0; s < NS; s++)
            for (int p = 0; p < 4; p++)
                if (d[s*4+p]) r[(p + FS + s) % 4] = 1'b1;
        return r;
    endfunction

    // ---- host-side tasks ----
    logic [31:0] idx_model = '0;

    task automatic idx_write(input logic [1:0] off, input logic [1:0] sz, input logic [31:0] d);
        logic [31:0] m;
        @(negedge clk);
        host_req = 1; host_win = 0; host_we = 1; host_off = {1'b0, off};
        host_size = sz; host_wdata = d;
        @(negedge clk);
        host_req = 0;
        chk(host_ack === 1'b1, "R2 index write ack", 32'(host_ack), 32'd1);
        m = lane_mask(exp_be(sz, off));
        idx_model = (idx_model & ~m) | ((d << (8 * off)) & m);
    endtask

    task automatic idx_read(input logic [1:0] off, input logic [1:0] sz);
        @(negedge clk);
        host_req = 1; host_win = 0; host_we = 0; host_off = {1'b0, off}; host_size = sz;
        @(negedge clk);
        host_req = 0;
        chk(host_ack === 1'b1, "R2 index read ack", 32'(host_ack), 32'd1);
        chk(host_rdata === exp_rd(idx_model, off, sz), "R2 index readback",
            host_rdata, exp_rd(idx_model, off, sz));
    endtask

    task automatic data_access(input logic we, input logic [2:0] off, input logic [1:0] sz,
                               input logic [31:0] wd, input logic [31:0] rv, input int dly);
        logic [31:0] ea;
        logic [3:0]  eb;
        ea = exp_xlate(idx_model, off);
        eb = exp_be(sz, off[1:0]);
        @(negedge clk);
        host_req = 1; host_win = 1; host_we = we; host_off = off; host_size = sz; host_wdata = wd;
        @(negedge clk);
        host_req = 0;
        chk(cfg_req === 1'b1, "R8 request raised", 32'(cfg_req), 32'd1);
        chk(cfg_addr === ea, fmt_tag(idx_model), cfg_addr, ea);
        chk(cfg_be === eb, "R7 byte enables", 32'(cfg_be), 32'(eb));
        chk(cfg_we === we, "R7 write flag", 32'(cfg_we), 32'(we));
        if (we)
            chk(cfg_wdata === ((wd << (8 * off[1:0])) & lane_mask(eb)), "R7 write lanes",
                cfg_wdata, (wd << (8 * off[1:0])) & lane_mask(eb));
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            chk(cfg_req === 1'b1 && cfg_addr === ea && host_ack === 1'b0, "R8 hold",
                cfg_addr, ea);
        end
        cfg_ack = 1; cfg_rdata = rv;
        @(negedge clk);
        cfg_ack = 0; cfg_rdata = $urandom;
        chk(host_ack === 1'b1 && cfg_req === 1'b0, "R8 completion",
            {30'b0, host_ack, cfg_req}, 32'd2);
        if (!we)
            chk(host_rdata === exp_rd(rv, off[1:0], sz), "R9 read data",
                host_rdata, exp_rd(rv, off[1:0], sz));
    endtask

    // ---- watchdog ----
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---- main sequence ----
    initial begin
        logic [31:0] r;
        logic [31:0] saved_addr;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        @(negedge clk);
        chk(cfg_req === 1'b0, "R1 cfg_req after reset", 32'(cfg_req), 32'd0);
        chk(host_ack === 1'b0, "R1 host_ack after reset", 32'(host_ack), 32'd0);
        idx_read(2'd0, 2'd2);   // R1: index reads zero

        // R2: byte-lane writes and sized reads of the index
        idx_write(2'd0, 2'd2, 32'hDEAD_BEEF);
        idx_read(2'd0, 2'd2);
        idx_write(2'd2, 2'd0, 32'h0000_00AB);
        idx_read(2'd0, 2'd2);
        idx_write(2'd1, 2'd1, 32'h0000_1234);
        idx_read(2'd2, 2'd1);
        idx_read(2'd3, 2'd0);
        chk(idx_model === 32'hDE12_34EF, "R2 lane model", idx_model, 32'hDE12_34EF);

        // R3: pass-through format
        idx_write(2'd0, 2'd2, 32'h8000_1234);
        data_access(1'b0, 3'd7, 2'd0, 32'h0, 32'hA1B2_C3D4, 0);
        // R4: Type-1 format, offset bit 2 lands in the address
        idx_write(2'd0, 2'd2, 32'h0001_0A05);
        data_access(1'b1, 3'd6, 2'd1, 32'h0000_5A5A, 32'h0, 2);
        // R5: one-hot select at bit 16 plus higher bits, lowest wins
        idx_write(2'd0, 2'd2, 32'h4001_034A);
        data_access(1'b0, 3'd2, 2'd1, 32'h0, 32'h1122_3344, 1);
        // R5: highest select bit only
        idx_write(2'd0, 2'd2, 32'h4000_0000);
        data_access(1'b0, 3'd0, 2'd2, 32'h0, 32'hCAFE_F00D, 0);
        // R6: no select bit
        idx_write(2'd0, 2'd2, 32'h0000_0524);
        data_access(1'b1, 3'd0, 2'd2, 32'h0BAD_F00D, 32'h0, 3);
        // R7: 4-byte access at offset 3 truncates enables to the top lane
        data_access(1'b1, 3'd3, 2'd3, 32'h8765_4321, 32'h0, 0);
        // R9: half read at offset 3 keeps only the top byte
        data_access(1'b0, 3'd3, 2'd1, 32'h0, 32'h99AA_BBCC, 1);

        // R11: a request during an outstanding transaction is ignored
        idx_write(2'd0, 2'd2, 32'h0000_2010);
        @(negedge clk);
        host_req = 1; host_win = 1; host_we = 0; host_off = 3'd1; host_size = 2'd0;
        @(negedge clk);
        saved_addr = cfg_addr;
        host_win = 0; host_we = 1; host_off = 3'd0; host_size = 2'd2; host_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        host_req = 0;
        chk(cfg_addr === saved_addr && host_ack === 1'b0, "R11 busy request ignored",
            cfg_addr, saved_addr);
        cfg_ack = 1; cfg_rdata = 32'h0000_7700;
        @(negedge clk);
        cfg_ack = 0;
        chk(host_rdata === 32'h77, "R11 original read completes", host_rdata, 32'h77);
        idx_read(2'd0, 2'd2);   // R11: index still 0x00002010

        // Random formats, offsets, sizes and acknowledge delays
        for (int it = 0; it < 150; it++) begin
            int kind;
            logic [31:0] v;
            kind = int'($urandom % 4);
            v = $urandom;
            case (kind)
                0: v[31] = 1'b1;
                1: begin v[31] = 1'b0; v[0] = 1'b1; end
                2: begin v[31] = 1'b0; v[0] = 1'b0;
                         if (v[30:11] == '0) v[20] = 1'b1; end
                default: begin v[31:11] = '0; v[0] = 1'b0; end
            endcase
            idx_write(2'd0, 2'd2, v);
            if ((it % 10) == 0) idx_read(2'($urandom), 2'($urandom));
            r = $urandom;
            data_access(1'($urandom), 3'($urandom), 2'($urandom), $urandom, r,
                        int'($urandom % 4));
        end

        // R10: interrupt rotation, directed single pins then random patterns
        dev_int = '0;
        dev_int[0] = 1'b1;          // slot 11 pin 0 -> line 3
        #1;
        chk(host_int === 4'b1000, "R10 slot 11 pin 0", 32'(host_int), 32'h8);
        dev_int = '0;
        dev_int[4*1 + 2] = 1'b1;    // slot 12 pin 2 -> line 2
        #1;
        chk(host_int === 4'b0100, "R10 slot 12 pin 2", 32'(host_int), 32'h4);
        for (int it = 0; it < 40; it++) begin
            @(negedge clk);
            dev_int = (it < 20) ? (NS*4)'(1) << ($urandom % (NS*4)) : (NS*4)'($urandom);
            #1;
            chk(host_int === exp_irq(dev_int), "R10 rotation", 32'(host_int),
                32'(exp_irq(dev_int)));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule